// File: doc/BRIEF.md
# Dual-Rate Timer with Modulo Compare

This block keeps two free-running timer counters that run off a reference-clock strobe. The fast counter steps once every `FAST_DIV` enabled reference cycles: with the default of 5 and a 5 MHz strobe, that is once per microsecond. The slow counter steps once every `SLOW_DIV` fast steps: with the default of 64, that is every 64 µs, or 15625 steps per second. A third divider counts `SLICE_LEN` enabled reference cycles and emits a one-cycle timeslice pulse. A low-priority scheduler uses that pulse to rotate its work. Every counter wraps freely at 2^`WIDTH`.

A single waiter compares one of the two counters against a target value. The target is compared as a point on a circle rather than as an unsigned number. The half range ahead of the current count is the future, and the half range behind it is the past. The waiter is a three-state machine:

- **IDLE**: nothing is armed.
- **WAIT**: a target is held and compared every cycle.
- **HIT**: the wait has completed, and `wait_done` is high.

Transitions:
- *arm* goes from any state to WAIT and captures the target and the counter select.
- *expire* goes from WAIT to HIT when the selected count is after the target.
- *clear* goes from WAIT or HIT to IDLE. A simultaneous arm wins over clear.

Top module: `dual_rate_timer`

## Requirements
- R1: After reset, both counters read 0, and `slice_pulse` and `wait_done` are low.
- R2: `fast_count` increases by 1 on each clock edge that completes `FAST_DIV` enabled (`ref_en` high) cycles since the last step. Cycles with `ref_en` low change no counter or divider.
- R3: `slow_count` increases by 1 on the same edge as every `SLOW_DIV`-th fast step, and on no other edge.
- R4: Both counters wrap from 2^`WIDTH`-1 to 0.
- R5: `slice_pulse` is high for exactly one cycle after each edge that completes `SLICE_LEN` enabled cycles since reset or since the last pulse.
- R6: An `arm` pulse captures `target` and `sel` (0 = fast counter, 1 = slow counter). In the cycle after the arm edge, `wait_done` is low.
- R7: In WAIT, the machine moves to HIT on an edge where (selected count − target), read as a signed `WIDTH`-bit number, is greater than zero. A difference of zero, or a negative difference (including exactly half the range), keeps it in WAIT.
- R8: A target already in the past sets `wait_done` in the second cycle after the arm edge.
- R9: `wait_done` stays high in HIT until `clear` or `arm` is sampled, even after the counter wraps past the target. `clear` returns the machine to IDLE with `wait_done` low. `arm` while in HIT starts a new wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference-clock strobe, one cycle high per reference period |
| arm | input | 1 | Start a wait on `target` |
| clear | input | 1 | Cancel or acknowledge the wait |
| sel | input | 1 | Counter compared by the wait: 0 fast, 1 slow |
| target | input | WIDTH | Wait target value |
| fast_count | output | WIDTH | Fast counter value |
| slow_count | output | WIDTH | Slow counter value |
| slice_pulse | output | 1 | One-cycle timeslice pulse |
| wait_done | output | 1 | The wait has completed (HIT state) |

## Verification
The bench models a reduced configuration (8-bit counters, dividers 5 and 4, a slice of 20) and predicts every output after every clock.

A wrong divider phase shows up on `fast_count` or `slice_pulse` within one divider period, at most 20 enabled cycles. A slow-chain error shows up within four fast steps. A waiter error shows up on `wait_done` within two cycles of an arm.

Every signed difference from −128 to +127 is swept on both counters, so an unsigned or off-by-one comparison changes `wait_done` at the exact boundary offsets 0, 1 and −128.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_WAIT = 2'd1,
        W_HIT  = 2'd2
    } wait_state_t;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the phase never leaves its range
    p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: without enable the phase holds
    p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_waiter.sv
module tmr_waiter
    import tmr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             clear,
    input  logic             sel,
    input  logic [WIDTH-1:0] target,
    input  logic [WIDTH-1:0] fast_cnt,
    input  logic [WIDTH-1:0] slow_cnt,
    output logic             done
);
    wait_state_t      state_q, state_d;
    logic [WIDTH-1:0] tgt_q;
    logic             sel_q;
    logic [WIDTH-1:0] diff;
    logic             is_after;

    always_comb begin
        diff     = (sel_q ? slow_cnt : fast_cnt) - tgt_q;
        is_after = !diff[WIDTH-1] && (diff != '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: if (arm) state_d = W_WAIT;
            W_WAIT: begin
                if (arm)           state_d = W_WAIT;
                else if (clear)    state_d = W_IDLE;
                else if (is_after) state_d = W_HIT;
            end
            W_HIT: begin
                if (arm)        state_d = W_WAIT;
                else if (clear) state_d = W_IDLE;
            end
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            tgt_q   <= '0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                tgt_q <= target;
                sel_q <= sel;
            end
        end
    end

    always_comb done = (state_q == W_HIT);

    // R6: an arm always leaves done low in the next cycle
    p_arm_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !done);

    // R9: done only drops after clear or arm
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(clear || arm));

    // R9: clear without arm lands in IDLE
    p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !arm) |=> (state_q == W_IDLE));

    // R7: done rises only out of a wait
    p_hit_from_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == W_WAIT));
endmodule

// File: rtl/dual_rate_timer.sv
module dual_rate_timer #(
    parameter int WIDTH     = 32,
    parameter int FAST_DIV  = 5,
    parameter int SLOW_DIV  = 64,
    parameter int SLICE_LEN = 5120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             arm,
    input  logic             clear,
    input  logic             sel,
    input  logic [WIDTH-1:0] target,
    output logic [WIDTH-1:0] fast_count,
    output logic [WIDTH-1:0] slow_count,
    output logic             slice_pulse,
    output logic             wait_done
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic             fast_tick, slow_tick, slice_tick;
    logic [WIDTH-1:0] fast_q, slow_q;
    logic             slice_q;

    tmr_divider #(.N(FAST_DIV)) u_fast_div (
        .clk(clk), .rst_n(rst_n), .en(ref_en), .tick(fast_tick));

    tmr_divider #(.N(SLOW_DIV)) u_slow_div (
        .clk(clk), .rst_n(rst_n), .en(fast_tick), .tick(slow_tick));

    tmr_divider #(.N(SLICE_LEN)) u_slice_div (
        .clk(clk), .rst_n(rst_n), .en(ref_en), .tick(slice_tick));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q  <= '0;
            slow_q  <= '0;
            slice_q <= 1'b0;
        end else begin
            if (fast_tick) fast_q <= fast_q + ONE;
            if (slow_tick) slow_q <= slow_q + ONE;
            slice_q <= slice_tick;
        end
    end

    tmr_waiter #(.WIDTH(WIDTH)) u_waiter (
        .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .sel(sel),
        .target(target), .fast_cnt(fast_q), .slow_cnt(slow_q), .done(wait_done));

    assign fast_count  = fast_q;
    assign slow_count  = slow_q;
    assign slice_pulse = slice_q;

    // R2 R4: the fast counter only steps by one, modulo the width
    p_fast_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_q != $past(fast_q)) |-> (fast_q == $past(fast_q) + ONE));

    // R3: the slow counter moves only on an edge that also moves the fast one
    p_slow_with_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slow_q) |-> !$stable(fast_q));

    // R2: nothing advances without the reference strobe
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> ($stable(fast_q) && !slice_q));
endmodule

// File: tb/dual_rate_timer_test.sv
module dual_rate_timer_test;
    localparam int W  = 8;
    localparam int FD = 5;
    localparam int SD = 4;
    localparam int SL = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_en = 1'b0, arm = 1'b0, clear = 1'b0, sel = 1'b0;
    logic [W-1:0] target = '0;
    logic [W-1:0] fast_count, slow_count;
    logic         slice_pulse, wait_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int           n_en = 0;
    logic [W-1:0] ef = '0, es = '0;
    logic         eslice = 1'b0, edone = 1'b0;
    int           mstate = 0;      // 0 idle, 1 wait, 2 hit
    logic         msel = 1'b0;
    logic [W-1:0] mtgt = '0;

    always #5 clk = ~clk;

    dual_rate_timer #(.WIDTH(W), .FAST_DIV(FD), .SLOW_DIV(SD), .SLICE_LEN(SL)) uut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .arm(arm), .clear(clear),
        .sel(sel), .target(target), .fast_count(fast_count),
        .slow_count(slow_count), .slice_pulse(slice_pulse), .wait_done(wait_done));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic after(input logic [W-1:0] c, input logic [W-1:0] t);
        logic [W-1:0] d;
        d = c - t;
        return !d[W-1] && (d != '0);
    endfunction

    task automatic tick(input logic en, input logic a, input logic c,
                        input logic s, input logic [W-1:0] t);
        logic [W-1:0] pf, ps;
        ref_en = en; arm = a; clear = c; sel = s; target = t;
        @(posedge clk);
        @(negedge clk);
        pf = ef; ps = es;
        eslice = 1'b0;
        if (en) begin
            n_en++;
            if (n_en % FD == 0) ef = ef + 1'b1;
            if (n_en % (FD * SD) == 0) es = es + 1'b1;
            if (n_en % SL == 0) eslice = 1'b1;
        end
        if (a) begin
            mstate = 1; msel = s; mtgt = t;
        end else if (c) begin
            mstate = 0;
        end else if (mstate == 1 && after(msel ? ps : pf, mtgt)) begin
            mstate = 2;
        end
        edone = (mstate == 2);
        check("R2 R4 fast_count", int'(fast_count), int'(ef));
        check("R3 R4 slow_count", int'(slow_count), int'(es));
        check("R5 slice_pulse", int'(slice_pulse), int'(eslice));
        check(a ? "R6 wait_done after arm" : "R7 R9 wait_done",
              int'(wait_done), int'(edone));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 fast_count", int'(fast_count), 0);
        check("R1 slow_count", int'(slow_count), 0);
        check("R1 slice_pulse", int'(slice_pulse), 0);
        check("R1 wait_done", int'(wait_done), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: counters through a full slow wrap, irregular strobe
        for (int i = 0; i < 6000; i++)
            tick((i % 7) != 3, 1'b0, 1'b0, 1'b0, '0);

        // R6 R7 R8 R9: every signed offset, both counters, counters frozen
        for (int s = 0; s < 2; s++) begin
            for (int d = -128; d < 128; d++) begin
                logic [W-1:0] cur;
                cur = s ? es : ef;
                tick(1'b0, 1'b1, 1'b0, s[0], cur - W'(d));
                tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
                check("R7 R8 offset verdict", int'(wait_done), (d > 0) ? 1 : 0);
                tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
                check("R9 clear", int'(wait_done), 0);
            end
        end

        // R9: arm while done restarts the wait
        tick(1'b0, 1'b1, 1'b0, 1'b0, ef - 8'd3);
        tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R8 past target", int'(wait_done), 1);
        tick(1'b0, 1'b1, 1'b0, 1'b0, ef + 8'd5);
        check("R9 rearm drops done", int'(wait_done), 0);
        tick(1'b0, 1'b1, 1'b0, 1'b0, ef + 8'd3);

        // R7 R9: running counter reaches a future target, then wraps past it
        for (int i = 0; i < 900; i++)
            tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check("R9 held across wrap", int'(wait_done), 1);

        // R7: slow-counter wait in the future while running
        tick(1'b1, 1'b1, 1'b0, 1'b1, es + 8'd2);
        for (int i = 0; i < 80; i++)
            tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check("R7 slow wait completes", int'(wait_done), 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule